// File: doc/BRIEF.md
# QED Instruction Duplication Unit

This unit sits between instruction fetch and decode in a 32-bit RISC-V pipeline that is under self-consistency checking. Each fetched word it accepts is issued unchanged as an "original". A copy of the word is also queued so that it can later be issued as a "duplicate". In the duplicate, every register operand is moved from the lower half of the integer register file to the upper half: register n becomes n+16, and x0 stays x0. Load and store duplicates also get a fixed offset added to their immediate, so they reach a separate region of data memory. The issued word takes the place of the fetched word on its way into decode.

A per-cycle select input chooses between two actions. One accepts a new original. The other issues the oldest pending duplicate, so any interleaving of the two streams can be produced. A combinational flag reports whether the incoming word belongs to the supported base-integer-plus-multiply subset. Words outside that subset are never issued. Two counters track how many originals and how many duplicates have been issued. When the two counts are equal and nonzero, both halves have executed the same program, so a paired register value supplied from the register file must match. A mismatch raises a failure flag.

Top module: `qed_dup_unit`

## Requirements
- R1: `in_legal` is high only for these words: LUI (0110111), AUIPC (0010111), JAL (1101111), JALR (1100111, funct3 000), branches (1100011, funct3 other than 010/011), loads (0000011, funct3 000/001/010/100/101), stores (0100011, funct3 000/001/010), OP-IMM (0010011, with funct7 0 for funct3 001 and funct7 0 or 0100000 for funct3 101), and OP (0110011, funct7 0 or 0000001 for any funct3, or 0100000 with funct3 000/101). Any other word, including all-zero and SYSTEM words, is illegal and is never issued.
- R2: A word is illegal if any register field it actually uses (rd bits 11:7, rs1 bits 19:15, rs2 bits 24:20) has bit 4 set. A shift amount in bits 24:20 of an immediate shift is not a register field and is not checked.
- R3: With `exec_dup` low, `in_valid` high, a legal word and a FIFO that is not full, the next cycle shows `out_valid`=1, `out_is_dup`=0 and `out_instr` equal to the input word unchanged.
- R4: A duplicate equals its original, except that each used register field with a nonzero value has 16 added (bit 4 set). A field holding x0 stays 0, and shift amounts are left unchanged.
- R5: In load and store duplicates, the 12-bit immediate (bits 31:20 for loads; bits 31:25 joined with bits 11:7 for stores) is replaced by the immediate plus `MEM_OFS` modulo 4096 (default 0x200).
- R6: Duplicates are issued one cycle after `exec_dup` is sampled high, oldest first, in the order their originals were accepted, whatever the interleaving.
- R7: `exec_dup` high with no pending duplicate gives `out_valid`=0 and changes no counter. While `exec_dup` is high, no original is accepted, and `in_ready` is 0.
- R8: When `DEPTH` (16) duplicates are pending, `in_ready` is 0 and an offered original is neither issued nor queued.
- R9: `qed_ready` is high exactly when the number of originals issued equals the number of duplicates issued and that number is nonzero.
- R10: `qed_fail` is high exactly when `qed_ready` is high and `chk_lo` differs from `chk_hi`.
- R11: A synchronous active-high `rst` empties the FIFO, clears both counters, and drives `out_valid` and `qed_ready` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Fetched word present |
| in_instr | input | 32 | Fetched instruction word |
| exec_dup | input | 1 | 1: issue oldest duplicate; 0: accept an original |
| in_legal | output | 1 | Fetched word is a legal lower-half instruction |
| in_ready | output | 1 | An original can be accepted this cycle |
| out_valid | output | 1 | Issued word present |
| out_instr | output | 32 | Word sent to decode |
| out_is_dup | output | 1 | Issued word is a duplicate |
| chk_lo | input | 32 | Lower-half register value under comparison |
| chk_hi | input | 32 | Paired upper-half register value |
| qed_ready | output | 1 | Both streams issued the same nonzero count |
| qed_fail | output | 1 | Paired values differ while ready |

## Verification
The remapping is tried on every instruction format. This separates R-, I-, S-, B-, U- and J-type handling of the rd, rs1 and rs2 fields. Operands equal to x0 show that the zero register is not remapped. An immediate shift with shift amount 20 shows whether the unit confuses that field with rs2. Loads and stores show whether the immediate offset is placed correctly, including the split store immediate. Illegal words are chosen so that each one fails a different rule: an upper-half destination, a bad funct7/funct3 pairing, a zero word and a SYSTEM word. Back-to-back pushes followed by pops, mixed interleavings and a full FIFO expose errors in ordering, pointer wrap and stall handling.

// File: rtl/qed_dup_unit.sv
module qed_dup_unit #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 16,
  parameter logic [11:0] MEM_OFS = 12'h200
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [31:0] in_instr,
  input  logic        exec_dup,
  output logic        in_legal,
  output logic        in_ready,
  output logic        out_valid,
  output logic [31:0] out_instr,
  output logic        out_is_dup,
  input  logic [31:0] chk_lo,
  input  logic [31:0] chk_hi,
  output logic        qed_ready,
  output logic        qed_fail
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [6:0] OP_LUI = 7'b0110111, OP_AUIPC = 7'b0010111,
    OP_JAL = 7'b1101111, OP_JALR = 7'b1100111, OP_BR = 7'b1100011,
    OP_LD = 7'b0000011, OP_ST = 7'b0100011, OP_IMM = 7'b0010011,
    OP_REG = 7'b0110011;

  // {supported, uses rd, uses rs1, uses rs2}
  function automatic logic [3:0] decode(input logic [31:0] w);
    logic [2:0] f3;
    logic [6:0] f7;
    logic ok, urd, urs1, urs2;
    f3 = w[14:12];
    f7 = w[31:25];
    ok = 1'b0; urd = 1'b0; urs1 = 1'b0; urs2 = 1'b0;
    case (w[6:0])
      OP_LUI, OP_AUIPC, OP_JAL: begin ok = 1'b1; urd = 1'b1; end
      OP_JALR: begin ok = (f3 == 3'b000); urd = 1'b1; urs1 = 1'b1; end
      OP_BR: begin
        ok = (f3 != 3'b010) && (f3 != 3'b011);
        urs1 = 1'b1; urs2 = 1'b1;
      end
      OP_LD: begin
        ok = (f3 != 3'b011) && (f3 != 3'b110) && (f3 != 3'b111);
        urd = 1'b1; urs1 = 1'b1;
      end
      OP_ST: begin ok = (f3 <= 3'b010); urs1 = 1'b1; urs2 = 1'b1; end
      OP_IMM: begin
        urd = 1'b1; urs1 = 1'b1;
        if (f3 == 3'b001)      ok = (f7 == 7'b0);
        else if (f3 == 3'b101) ok = (f7 == 7'b0) || (f7 == 7'b0100000);
        else                   ok = 1'b1;
      end
      OP_REG: begin
        urd = 1'b1; urs1 = 1'b1; urs2 = 1'b1;
        ok = (f7 == 7'b0) || (f7 == 7'b0000001) ||
             ((f7 == 7'b0100000) && ((f3 == 3'b000) || (f3 == 3'b101)));
      end
      default: ;
    endcase
    return {ok, urd, urs1, urs2};
  endfunction

  function automatic logic [31:0] shadow(input logic [31:0] w);
    logic [3:0]  d;
    logic [31:0] r;
    logic [11:0] imm;
    d = decode(w);
    r = w;
    if (d[2] && (w[11:7]  != 5'd0)) r[11] = 1'b1;
    if (d[1] && (w[19:15] != 5'd0)) r[19] = 1'b1;
    if (d[0] && (w[24:20] != 5'd0)) r[24] = 1'b1;
    if (w[6:0] == OP_LD) r[31:20] = w[31:20] + MEM_OFS;
    if (w[6:0] == OP_ST) begin
      imm = {w[31:25], w[11:7]} + MEM_OFS;
      r[31:25] = imm[11:5];
      r[11:7]  = imm[4:0];
    end
    return r;
  endfunction

  logic [31:0]      q [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [AW:0]      cnt;
  logic [CNT_W-1:0] orig_cnt, dup_cnt;
  logic [3:0]       in_dec;
  logic             full, push, pop;

  assign in_dec   = decode(in_instr);
  assign in_legal = in_dec[3] && !(in_dec[2] && in_instr[11]) &&
                    !(in_dec[1] && in_instr[19]) && !(in_dec[0] && in_instr[24]);
  assign full     = (cnt == (AW+1)'(DEPTH));
  assign in_ready = !exec_dup && !full;
  assign push     = in_ready && in_valid && in_legal;
  assign pop      = exec_dup && (cnt != '0);

  always_ff @(posedge clk)
    if (push) q[wp] <= in_instr;

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0; rp <= '0; cnt <= '0;
      orig_cnt <= '0; dup_cnt <= '0;
      out_valid <= 1'b0; out_is_dup <= 1'b0; out_instr <= '0;
    end else begin
      out_valid  <= push || pop;
      out_is_dup <= pop;
      if (push) begin
        out_instr <= in_instr;
        wp <= wp + 1'b1;
        cnt <= cnt + 1'b1;
        orig_cnt <= orig_cnt + 1'b1;
      end else if (pop) begin
        out_instr <= shadow(q[rp]);
        rp <= rp + 1'b1;
        cnt <= cnt - 1'b1;
        dup_cnt <= dup_cnt + 1'b1;
      end
    end
  end

  assign qed_ready = (orig_cnt == dup_cnt) && (orig_cnt != '0);
  assign qed_fail  = qed_ready && (chk_lo != chk_hi);
endmodule

module qed_dup_unit_chk #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [31:0] in_instr,
  input logic        exec_dup,
  input logic        in_legal,
  input logic        in_ready,
  input logic        out_valid,
  input logic [31:0] out_instr,
  input logic        out_is_dup,
  input logic        qed_ready,
  input logic        qed_fail,
  input logic [AW:0] cnt
);
  p_orig_passthru_r3: assert property (@(posedge clk) disable iff (rst)
    (!exec_dup && in_valid && in_legal && in_ready) |=>
      (out_valid && !out_is_dup && out_instr == $past(in_instr)));

  p_illegal_dropped_r1: assert property (@(posedge clk) disable iff (rst)
    (!exec_dup && in_valid && !in_legal) |=> !out_valid);

  p_empty_dup_r7: assert property (@(posedge clk) disable iff (rst)
    (exec_dup && cnt == '0) |=> !out_valid);

  p_dup_blocks_orig_r7: assert property (@(posedge clk) disable iff (rst)
    exec_dup |-> !in_ready);

  p_full_stall_r8: assert property (@(posedge clk) disable iff (rst)
    (cnt == (AW+1)'(DEPTH)) |-> !in_ready);

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    cnt <= (AW+1)'(DEPTH));

  p_reg_rd_upper_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_is_dup && out_instr[6:0] == 7'b0110011) |->
      (out_instr[11] || out_instr[11:7] == 5'd0));

  p_fail_gated_r10: assert property (@(posedge clk) disable iff (rst)
    qed_fail |-> qed_ready);

  p_reset_clears_r11: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !qed_ready));
endmodule

bind qed_dup_unit qed_dup_unit_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_instr(in_instr),
  .exec_dup(exec_dup), .in_legal(in_legal), .in_ready(in_ready),
  .out_valid(out_valid), .out_instr(out_instr), .out_is_dup(out_is_dup),
  .qed_ready(qed_ready), .qed_fail(qed_fail), .cnt(cnt)
);

// File: tb/qed_dup_unit_tb.sv
module qed_dup_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;
  // {word, legal, expected duplicate}
  localparam logic [64:0] VEC [NV] = '{
    {32'h003100B3, 1'b1, 32'h013908B3},  // add x1,x2,x3
    {32'h027302B3, 1'b1, 32'h037B0AB3},  // mul x5,x6,x7
    {32'h00500213, 1'b1, 32'h00500A13},  // addi x4,x0,5
    {32'h0044A403, 1'b1, 32'h204CAC03},  // lw x8,4(x9)
    {32'h00A5A423, 1'b1, 32'h21ADA423},  // sw x10,8(x11)
    {32'h123457B7, 1'b1, 32'h12345FB7},  // lui x15
    {32'h00208463, 1'b1, 32'h01288463},  // beq x1,x2
    {32'h01419193, 1'b1, 32'h01499993},  // slli x3,x3,20
    {32'h000000EF, 1'b1, 32'h000008EF},  // jal x1
    {32'h002088B3, 1'b0, 32'h0},         // add x17 (upper rd)
    {32'h00000000, 1'b0, 32'h0},
    {32'h40001033, 1'b0, 32'h0},         // bad funct7/funct3
    {32'h00000073, 1'b0, 32'h0}          // system
  };

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, exec_dup = 1'b0;
  logic [31:0] in_instr = '0, chk_lo = '0, chk_hi = '0;
  logic in_legal, in_ready, out_valid, out_is_dup, qed_ready, qed_fail;
  logic [31:0] out_instr;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qed_dup_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_instr(in_instr),
    .exec_dup(exec_dup), .in_legal(in_legal), .in_ready(in_ready),
    .out_valid(out_valid), .out_instr(out_instr), .out_is_dup(out_is_dup),
    .chk_lo(chk_lo), .chk_hi(chk_hi), .qed_ready(qed_ready), .qed_fail(qed_fail)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [31:0] w, input logic d);
    in_valid = v; in_instr = w; exec_dup = d;
    #1;
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R11 out_valid after reset", out_valid, 0);
    chk("R11 qed_ready after reset", qed_ready, 0);
    chk("R8 in_ready when empty", in_ready, 1);
    chk_lo = 32'd3; chk_hi = 32'd4;
    #1 chk("R10 fail gated when not ready", qed_fail, 0);

    // R1 R2 R3 R4 R5 table walk
    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VEC[i][64:33], 1'b0);
      chk("R1 R2 legality flag", in_legal, VEC[i][32]);
      tick();
      chk("R3 original issued", out_valid, VEC[i][32]);
      if (VEC[i][32]) begin
        chk("R3 original unchanged", out_instr, VEC[i][64:33]);
        chk("R3 original tag", out_is_dup, 0);
        chk("R9 not ready after original", qed_ready, 0);
        drive(1'b0, 32'h0, 1'b1);
        tick();
        chk("R4 duplicate issued", out_valid, 1);
        chk("R4 duplicate tag", out_is_dup, 1);
        chk("R4 R5 duplicate word", out_instr, VEC[i][31:0]);
        chk("R9 ready after pair", qed_ready, 1);
      end
    end

    // R10 comparison
    chk_lo = 32'd7; chk_hi = 32'd7;
    #1 chk("R10 equal pair", qed_fail, 0);
    chk_hi = 32'd9;
    #1 chk("R10 mismatch flagged", qed_fail, 1);
    chk_hi = 32'd7;

    // R7 empty duplicate request, original offered alongside
    drive(1'b1, 32'h00500213, 1'b1);
    chk("R7 in_ready low while exec_dup", in_ready, 0);
    tick();
    chk("R7 empty dup not issued", out_valid, 0);
    chk("R7 counters unchanged", qed_ready, 1);
    drive(1'b0, 32'h0, 1'b1);
    tick();
    chk("R7 original not queued during dup", out_valid, 0);

    // R6 interleaving A A' ... 
    drive(1'b1, 32'h003100B3, 1'b0); tick();
    drive(1'b1, 32'h027302B3, 1'b0); tick();
    drive(1'b0, 32'h0, 1'b1); tick();
    chk("R6 first dup is oldest", out_instr, 32'h013908B3);
    drive(1'b1, 32'h123457B7, 1'b0); tick();
    chk("R9 unequal counts", qed_ready, 0);
    drive(1'b0, 32'h0, 1'b1); tick();
    chk("R6 second dup", out_instr, 32'h037B0AB3);
    drive(1'b0, 32'h0, 1'b1); tick();
    chk("R6 third dup", out_instr, 32'h12345FB7);
    chk("R9 ready after interleave", qed_ready, 1);

    // R8 fill FIFO
    for (int k = 1; k <= 16; k++) begin
      drive(1'b1, (32'(k) << 20) | 32'h93, 1'b0);
      tick();
    end
    drive(1'b1, 32'h01100093, 1'b0);
    chk("R8 in_ready low when full", in_ready, 0);
    tick();
    chk("R8 original stalled", out_valid, 0);
    for (int k = 1; k <= 16; k++) begin
      drive(1'b0, 32'h0, 1'b1);
      tick();
      chk("R6 ordered dup after fill", out_instr, (32'(k) << 20) | 32'h893);
    end
    drive(1'b0, 32'h0, 1'b1);
    tick();
    chk("R8 stalled original never queued", out_valid, 0);
    chk("R9 ready after drain", qed_ready, 1);

    // R11 reset mid-stream
    drive(1'b1, 32'h003100B3, 1'b0); tick();
    drive(1'b1, 32'h027302B3, 1'b0);
    rst = 1'b1;
    tick();
    rst = 1'b0;
    chk("R11 out_valid cleared", out_valid, 0);
    chk("R11 counters cleared", qed_ready, 0);
    drive(1'b0, 32'h0, 1'b1);
    tick();
    chk("R11 FIFO emptied", out_valid, 0);
    drive(1'b0, 32'h0, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule